// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 48-bit virtual address into a 52-bit physical address by reading page table entries from memory, one level after another. A walk starts from a root register that holds the physical base of the top table. Each step reads one 64-bit entry over a simple request/response memory port and inspects two flags: a present flag and a huge-page flag. A clear present flag ends the walk at once with a fault. A huge-page flag in the second or third table ends the walk early with a 1 GB or 2 MB mapping.

When a walk finishes, the block reports four things. These are the physical address, the page size it resolved to, the table that faulted (if any), and the number of memory reads it issued. A host pulses the start input while the walker is idle, serves the reads, and collects the result on the one-cycle completion pulse. Only one read is outstanding at any time.

Top module: `pt_walker`

## Requirements
- R1: After reset, busy_o, done_o, fault_o and req_valid_o are low and reads_o is zero.
- R2: The read for table k (k = 1 top .. 4 last) targets table base + 8 × index. The index is virtual address bits 47:39, 38:30, 29:21 or 20:12 for k = 1..4. The first base is root_i. Each later base is entry bits 51:12 followed by twelve zero bits.
- R3: An entry with bit 0 clear stops the walk with no further read. done_o and fault_o pulse together, and fault_level_o gives k−1 of the faulting table (0 = top).
- R4: An entry in table 2 with bit 0 and bit 7 set ends the walk as a 1 GB page. paddr_o = {entry[51:30], va[29:0]} and page_size_o = 2.
- R5: An entry in table 3 with bit 0 and bit 7 set ends the walk as a 2 MB page. paddr_o = {entry[51:21], va[20:0]} and page_size_o = 1.
- R6: A present entry in table 4 ends the walk as a 4 KB page. paddr_o = {entry[51:12], va[11:0]} and page_size_o = 0. Bit 7 has no effect in tables 1 and 4.
- R7: reads_o at completion equals the number of tables read, counting the one that faulted (1 to 4).
- R8: While a response is awaited, req_valid_o stays low. While req_valid_o is high and req_ready_i low, req_valid_o and req_addr_o hold.
- R9: start_i is taken only when idle. busy_o rises the cycle after an accepted start and falls with done_o. A start during a walk changes neither the reads nor the result.
- R10: done_o is high for exactly one cycle per walk, and fault_o is never high without done_o.
- R11: Entry bits 63:52, 11:8 and 6:1 have no effect on addresses or results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk (taken when idle) |
| vaddr_i | input | 48 | Virtual address to translate |
| root_i | input | 52 | Physical base of the top table |
| busy_o | output | 1 | Walk in progress |
| req_valid_o | output | 1 | Memory read request valid |
| req_ready_i | input | 1 | Memory accepts the request |
| req_addr_o | output | 52 | Physical address of the entry to read |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | 64 | Entry read from memory |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Walk ended on a non-present entry |
| fault_level_o | output | 2 | Faulting table, 0 = top |
| paddr_o | output | 52 | Translated physical address |
| page_size_o | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| reads_o | output | 3 | Memory reads issued in this walk |

## Verification
Walks are run on addresses that resolve at each of the three leaf depths. They are also run on addresses that fault at each of the four tables. Together these separate early-exit logic from fault logic and show that each read count comes from the level actually reached. Leaf entries carry set bits outside the frame field, and a top-level entry carries a huge flag, which exposes masking errors and a huge-page test applied at the wrong level. Repeat walks with slow memory, a stalled request and a start pulse mid-walk check that the request holds steady and that a stray start is ignored.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int VA_W      = 48;
  localparam int PA_W      = 52;
  localparam int ENT_W     = 64;
  localparam int IDX_W     = 9;
  localparam int OFF_W     = 12;
  localparam int N_LVL     = 4;
  localparam int LVL_W     = $clog2(N_LVL);
  localparam int CNT_W     = $clog2(N_LVL + 1);
  localparam int ENT_SHIFT = $clog2(ENT_W / 8);
  localparam int OFF_2M    = OFF_W + IDX_W;
  localparam int OFF_1G    = OFF_W + 2 * IDX_W;
  localparam int BIT_PRES  = 0;
  localparam int BIT_HUGE  = 7;
  localparam int LVL_1G    = N_LVL - 3;
  localparam int LVL_2M    = N_LVL - 2;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} wstate_e;
  typedef enum logic [1:0] {PG_4K = 2'd0, PG_2M = 2'd1, PG_1G = 2'd2} pgsize_e;

  // Base of the next table named by a pointer entry.
  function automatic logic [PA_W-1:0] next_table(input logic [ENT_W-1:0] ent);
    return {ent[PA_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  // Leaf physical address: frame bits above the page offset, offset from VA.
  function automatic logic [PA_W-1:0] leaf_pa(input logic [PA_W-1:OFF_W] frame,
                                               input logic [OFF_1G-1:0] voff,
                                               input pgsize_e sz);
    case (sz)
      PG_1G:   return {frame[PA_W-1:OFF_1G], voff[OFF_1G-1:0]};
      PG_2M:   return {frame[PA_W-1:OFF_2M], voff[OFF_2M-1:0]};
      default: return {frame[PA_W-1:OFF_W], voff[OFF_W-1:0]};
    endcase
  endfunction
endpackage

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen
  import pgw_pkg::*;
(
  input  logic [PA_W-1:0]       base_i,
  input  logic [VA_W-1:OFF_W]   vpn_i,
  input  logic [LVL_W-1:0]      lvl_i,
  output logic [PA_W-1:0]       addr_o
);
  logic [IDX_W-1:0] idx [N_LVL];

  for (genvar g = 0; g < N_LVL; g++) begin : g_idx
    assign idx[g] = vpn_i[OFF_W + IDX_W*(N_LVL-g) - 1 -: IDX_W];
  end

  assign addr_o = base_i + (PA_W'(idx[lvl_i]) << ENT_SHIFT);
endmodule

// File: rtl/pgw_entry_dec.sv
module pgw_entry_dec
  import pgw_pkg::*;
(
  input  logic [ENT_W-1:0] ent_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             present_o,
  output logic             leaf_o,
  output pgsize_e          size_o,
  output logic [PA_W-1:0]  next_base_o
);
  logic huge;
  logic unused_ent;

  assign present_o   = ent_i[BIT_PRES];
  assign huge        = ent_i[BIT_HUGE];
  assign next_base_o = next_table(ent_i);
  assign unused_ent  = ^{ent_i[ENT_W-1:PA_W], ent_i[OFF_W-1:BIT_HUGE+1],
                         ent_i[BIT_HUGE-1:BIT_PRES+1]};

  always_comb begin
    leaf_o = 1'b0;
    size_o = PG_4K;
    if (lvl_i == LVL_W'(N_LVL - 1)) begin
      leaf_o = 1'b1;
    end else if (huge && lvl_i == LVL_W'(LVL_1G)) begin
      leaf_o = 1'b1;
      size_o = PG_1G;
    end else if (huge && lvl_i == LVL_W'(LVL_2M)) begin
      leaf_o = 1'b1;
      size_o = PG_2M;
    end
  end
endmodule

// File: rtl/pgw_pa_form.sv
module pgw_pa_form
  import pgw_pkg::*;
(
  input  logic [PA_W-1:OFF_W] frame_i,
  input  logic [OFF_1G-1:0]   voff_i,
  input  pgsize_e             size_i,
  output logic [PA_W-1:0]     pa_o
);
  assign pa_o = leaf_pa(frame_i, voff_i, size_i);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pgw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [PA_W-1:0]  root_i,
  output logic             busy_o,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic [PA_W-1:0]  req_addr_o,
  input  logic             rsp_valid_i,
  input  logic [ENT_W-1:0] rsp_data_i,
  output logic             done_o,
  output logic             fault_o,
  output logic [LVL_W-1:0] fault_level_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic [1:0]       page_size_o,
  output logic [CNT_W-1:0] reads_o
);
  wstate_e          state_q;
  logic [VA_W-1:0]  va_q;
  logic [PA_W-1:0]  base_q;
  logic [LVL_W-1:0] lvl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q, fault_q;
  logic [LVL_W-1:0] flvl_q;
  logic [PA_W-1:0]  pa_q;
  pgsize_e          size_q;

  // Named events for the checker.
  logic req_fire, rsp_take, walk_start;
  logic ent_present, ent_leaf;
  pgsize_e ent_size;
  logic [PA_W-1:0] ent_next, leaf_addr;

  assign walk_start = (state_q == ST_IDLE) && start_i;
  assign req_fire   = req_valid_o && req_ready_i;
  assign rsp_take   = (state_q == ST_WAIT) && rsp_valid_i;

  pgw_addr_gen u_addr (
    .base_i (base_q),
    .vpn_i  (va_q[VA_W-1:OFF_W]),
    .lvl_i  (lvl_q),
    .addr_o (req_addr_o)
  );

  pgw_entry_dec u_dec (
    .ent_i       (rsp_data_i),
    .lvl_i       (lvl_q),
    .present_o   (ent_present),
    .leaf_o      (ent_leaf),
    .size_o      (ent_size),
    .next_base_o (ent_next)
  );

  pgw_pa_form u_pa (
    .frame_i (rsp_data_i[PA_W-1:OFF_W]),
    .voff_i  (va_q[OFF_1G-1:0]),
    .size_i  (ent_size),
    .pa_o    (leaf_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      lvl_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      flvl_q  <= '0;
      pa_q    <= '0;
      size_q  <= PG_4K;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (walk_start) begin
            va_q    <= vaddr_i;
            base_q  <= root_i;
            lvl_q   <= '0;
            cnt_q   <= '0;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (req_fire) begin
            cnt_q   <= cnt_q + CNT_W'(1);
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_take) begin
            if (!ent_present) begin
              done_q  <= 1'b1;
              fault_q <= 1'b1;
              flvl_q  <= lvl_q;
              pa_q    <= '0;
              state_q <= ST_IDLE;
            end else if (ent_leaf) begin
              done_q  <= 1'b1;
              flvl_q  <= '0;
              pa_q    <= leaf_addr;
              size_q  <= ent_size;
              state_q <= ST_IDLE;
            end else begin
              base_q  <= ent_next;
              lvl_q   <= lvl_q + LVL_W'(1);
              state_q <= ST_REQ;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign req_valid_o   = (state_q == ST_REQ);
  assign done_o        = done_q;
  assign fault_o       = fault_q;
  assign fault_level_o = flvl_q;
  assign paddr_o       = pa_q;
  assign page_size_o   = size_q;
  assign reads_o       = cnt_q;
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker
  import pgw_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             req_valid_o,
  input logic             req_ready_i,
  input logic [PA_W-1:0]  req_addr_o,
  input logic             done_o,
  input logic             fault_o,
  input logic [LVL_W-1:0] fault_level_o,
  input logic [1:0]       page_size_o,
  input logic [CNT_W-1:0] reads_o,
  input logic             req_fire,
  input logic             rsp_take
);
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));

  assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_valid_o);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_fault_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> done_o);

  assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(rsp_take)));

  assert_fault_reads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (reads_o == CNT_W'(fault_level_o) + CNT_W'(1)));

  assert_1g_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !fault_o && page_size_o == 2'd2) |-> (reads_o == CNT_W'(LVL_1G + 1)));

  assert_2m_reads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !fault_o && page_size_o == 2'd1) |-> (reads_o == CNT_W'(LVL_2M + 1)));

  assert_4k_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !fault_o && page_size_o == 2'd0) |-> (reads_o == CNT_W'(N_LVL)));
endmodule

bind pt_walker pgw_checker u_pgw_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .busy_o        (busy_o),
  .req_valid_o   (req_valid_o),
  .req_ready_i   (req_ready_i),
  .req_addr_o    (req_addr_o),
  .done_o        (done_o),
  .fault_o       (fault_o),
  .fault_level_o (fault_level_o),
  .page_size_o   (page_size_o),
  .reads_o       (reads_o),
  .req_fire      (req_fire),
  .rsp_take      (rsp_take)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [47:0] vaddr_i = '0;
  logic [51:0] root_i = 52'h10_0000;
  logic        busy_o, req_valid_o;
  logic        req_ready_i = 1'b0;
  logic [51:0] req_addr_o;
  logic        rsp_valid_i = 1'b0;
  logic [63:0] rsp_data_i = '0;
  logic        done_o, fault_o;
  logic [1:0]  fault_level_o;
  logic [51:0] paddr_o;
  logic [1:0]  page_size_o;
  logic [2:0]  reads_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  bit [63:0] mem [longint unsigned];

  always #4 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vaddr_i(vaddr_i), .root_i(root_i),
    .busy_o(busy_o), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_addr_o(req_addr_o), .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
    .done_o(done_o), .fault_o(fault_o), .fault_level_o(fault_level_o),
    .paddr_o(paddr_o), .page_size_o(page_size_o), .reads_o(reads_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic longint unsigned rd(input longint unsigned a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  function automatic longint unsigned vidx(input logic [47:0] va, input int lvl);
    return (longint'(va) >> (39 - 9 * lvl)) & 511;
  endfunction

  task automatic put(input longint unsigned base, input logic [47:0] va,
                     input int lvl, input longint unsigned val);
    mem[base + vidx(va, lvl) * 8] = val;
  endtask

  // Behavioural model of one walk.
  longint unsigned m_addr [4];
  int              m_n;
  bit              m_fault;
  int              m_lvl;
  longint unsigned m_pa;
  int              m_size;

  task automatic model(input logic [47:0] va);
    longint unsigned base = root_i;
    longint unsigned v = va;
    m_fault = 0; m_pa = 0; m_size = 0; m_lvl = 0; m_n = 0;
    for (int l = 0; l < 4; l++) begin
      longint unsigned e;
      m_addr[l] = base + vidx(va, l) * 8;
      m_n = l + 1;
      e = rd(m_addr[l]);
      if (e[0] == 1'b0) begin
        m_fault = 1; m_lvl = l;
        return;
      end
      if (l == 1 && e[7]) begin
        m_pa = (e & 64'h000F_FFFF_C000_0000) | (v & 64'h3FFF_FFFF);
        m_size = 2;
        return;
      end
      if (l == 2 && e[7]) begin
        m_pa = (e & 64'h000F_FFFF_FFE0_0000) | (v & 64'h1F_FFFF);
        m_size = 1;
        return;
      end
      if (l == 3) begin
        m_pa = (e & 64'h000F_FFFF_FFFF_F000) | (v & 64'hFFF);
        m_size = 0;
        return;
      end
      base = e & 64'h000F_FFFF_FFFF_F000;
    end
  endtask

  // One walk, compared against the model at every falling edge.
  task automatic walk(input logic [47:0] va, input int lat, input int stall,
                      input bit inject, input logic [47:0] va2, input string tag);
    int k = 0;
    int wait_lat = 0;
    int stall_left = stall;
    bit expect_done = 0;
    bit ended = 0;
    longint unsigned pend = 0;
    model(va);
    @(negedge clk);
    start_i = 1'b1;
    vaddr_i = va;
    @(negedge clk);
    start_i = 1'b0;
    vaddr_i = 48'h0;
    chk(busy_o == 1'b1, "R9", {tag, " busy after start"}, 64'(busy_o), 64'd1);
    for (int cyc = 0; cyc < 300 && !ended; cyc++) begin
      req_ready_i = 1'b0;
      if (rsp_valid_i) rsp_valid_i = 1'b0;
      if (inject && cyc == 2) begin start_i = 1'b1; vaddr_i = va2; end
      else if (inject && cyc == 3) begin start_i = 1'b0; vaddr_i = 48'h0; end
      if (expect_done) begin
        chk(done_o == 1'b1, "R10", {tag, " done pulse"}, 64'(done_o), 64'd1);
        chk(fault_o == m_fault, "R3", {tag, " fault flag"}, 64'(fault_o), 64'(m_fault));
        chk(reads_o == 3'(m_n), "R7", {tag, " read count"}, 64'(reads_o), 64'(m_n));
        chk(busy_o == 1'b0, "R9", {tag, " idle at done"}, 64'(busy_o), 64'd0);
        if (m_fault)
          chk(fault_level_o == 2'(m_lvl), "R3", {tag, " fault level"},
              64'(fault_level_o), 64'(m_lvl));
        else begin
          chk(paddr_o == 52'(m_pa), m_size == 2 ? "R4" : (m_size == 1 ? "R5" : "R6"),
              {tag, " physical address"}, 64'(paddr_o), m_pa);
          chk(page_size_o == 2'(m_size), "R6", {tag, " page size"},
              64'(page_size_o), 64'(m_size));
        end
        ended = 1;
      end else begin
        if (done_o || fault_o)
          chk(1'b0, "R10", {tag, " early done"}, 64'({done_o, fault_o}), 64'd0);
        if (wait_lat > 0) begin
          if (req_valid_o)
            chk(1'b0, "R8", {tag, " request while waiting"}, 64'(req_valid_o), 64'd0);
          wait_lat--;
          if (wait_lat == 0) begin
            rsp_valid_i = 1'b1;
            rsp_data_i = rd(pend);
            expect_done = (k == m_n);
          end
        end else if (req_valid_o) begin
          if (k >= m_n) begin
            chk(1'b0, "R3", {tag, " extra read"}, 64'(req_addr_o), 64'd0);
            ended = 1;
          end else begin
            chk(req_addr_o == 52'(m_addr[k]), "R2", {tag, " entry address"},
                64'(req_addr_o), m_addr[k]);
            if (stall_left > 0) begin
              stall_left--;
            end else begin
              req_ready_i = 1'b1;
              pend = m_addr[k];
              k++;
              wait_lat = lat;
              stall_left = stall;
            end
          end
        end
      end
      if (!ended) @(negedge clk);
    end
    if (!expect_done) chk(1'b0, "R10", {tag, " walk never completed"}, 64'd0, 64'd1);
    start_i = 1'b0;
    req_ready_i = 1'b0;
    @(negedge clk);
    chk(done_o == 1'b0, "R10", {tag, " done drops"}, 64'(done_o), 64'd0);
  endtask

  localparam logic [47:0] VA_A = 48'h7FFF_F7DD_5000;
  localparam logic [47:0] VA_B = 48'h0000_4060_1234;
  localparam logic [47:0] VA_C = 48'h0123_4567_89AB;
  localparam logic [47:0] VA_D = 48'hFF80_0000_0000;

  initial begin
    longint unsigned r = 64'h10_0000;
    // 4 KB path for VA_A; leaf carries junk outside the frame field (R11, R6).
    put(r, VA_A, 0, 64'h20_0001);
    put(64'h20_0000, VA_A, 1, 64'h30_0001);
    put(64'h30_0000, VA_A, 2, 64'h40_0001);
    put(64'h40_0000, VA_A, 3, 64'hFFF0_000A_BCDE_0FFF);
    // 2 MB path for VA_B; top entry has the huge flag, which must not matter (R6).
    put(r, VA_B, 0, 64'h7000_0000_0050_0081);
    put(64'h50_0000, VA_B, 1, 64'h60_0001);
    put(64'h60_0000, VA_B, 2, 64'h8000_00AB_CDE0_0F81);
    // 1 GB path for VA_C.
    put(r, VA_C, 0, 64'h70_0001);
    put(64'h70_0000, VA_C, 1, 64'h0008_0012_4000_0181);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !fault_o && !req_valid_o && reads_o == 0, "R1",
        "reset state", 64'({busy_o, done_o, fault_o, req_valid_o, reads_o}), 64'd0);

    walk(VA_A, 1, 0, 0, 48'h0, "R6 R11 4K walk");
    walk(VA_B, 2, 0, 0, 48'h0, "R5 2M walk");
    walk(VA_C, 1, 0, 0, 48'h0, "R4 1G walk");
    walk(VA_D, 1, 0, 0, 48'h0, "R3 fault top");
    walk(VA_A ^ 48'h1000, 1, 0, 0, 48'h0, "R3 fault last");
    walk(VA_A ^ (48'h1 << 21), 2, 0, 0, 48'h0, "R3 fault third");
    walk(VA_A ^ (48'h1 << 30), 1, 0, 0, 48'h0, "R7 fault second");
    walk(VA_A, 3, 3, 0, 48'h0, "R8 stalled walk");
    walk(VA_B, 2, 1, 1, VA_C, "R9 start ignored");
    walk(VA_C, 1, 2, 1, VA_A, "R9 start ignored 1G");
    walk(VA_A, 1, 0, 0, 48'h0, "R2 repeat 4K");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule